// File: doc/BRIEF.md
# Processor Power Mode Controller

This block steps a processor core between full operation and four reduced-power conditions: nap, a snooping variant of nap called doze, sleep, and deep sleep. For each of seven clock domains it drives an enable: instruction fetch, functional units, bus snooping, thermal monitor, time base/decrementer, test port and PLL. Before any clock is gated it raises a quiesce request towards system logic and waits for the matching acknowledge.

A two-bit mode input selects the target condition while the core is running. A wake input returns the core to full operation. A snoop-needed input, together with a dropped acknowledge, opens a temporary doze excursion from nap so that bus traffic can be snooped. A PLL-lock input gates the way out of deep sleep: the PLL enable comes back alone, and the other domains wait until lock is reported. Reset is asynchronous and active-low, and its release is synchronized inside the block.

Top module: `pwr_mode_ctrl`

## Requirements
- R1: After reset all seven enables are high and the quiesce request is low. Enable bit positions are 0 fetch, 1 functional units, 2 snoop, 3 thermal, 4 time base, 5 test port, 6 PLL.
- R2: In run, with wake low, mode code 01 raises the quiesce request on the next cycle while all enables stay high. The enables keep that value until acknowledge is sampled high. The cycle after that, only thermal, time base, test port and PLL are enabled (7'h78).
- R3: In run, with wake low, mode code 10 uses the same handshake. After acknowledge only the PLL is enabled (7'h40).
- R4: In nap, acknowledge low with snoop-needed high adds the snoop enable on the next cycle (7'h7C). The controller returns to 7'h78 only after acknowledge is sampled high again. Acknowledge low without snoop-needed leaves nap unchanged.
- R5: Wake high in nap, doze, sleep or while waiting for acknowledge gives all enables high and the request low on the next cycle. Wake takes priority over a doze excursion or a deeper request in the same cycle.
- R6: Deep sleep is reached only from sleep. Mode code 11 in sleep gives all enables low on the next cycle. Mode code 11 in run goes only as far as sleep (7'h40).
- R7: Wake in deep sleep enables only the PLL on the next cycle, with the request held high. The wake pulse need not be held. The cycle after PLL lock is sampled high, all enables are high and the request is low.
- R8: Mode requests are ignored in nap, doze and sleep, except the deep request (11) in sleep. For example, code 10 in nap or code 01 in sleep leaves the enables unchanged.
- R9: In sleep, dropping acknowledge with snoop-needed high has no effect, and the enables stay 7'h40.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_i | input | 2 | Target mode: 00 none, 01 nap, 10 sleep, 11 deep sleep |
| wake_i | input | 1 | Wake / interrupt event |
| snoop_need_i | input | 1 | Bus traffic needs snooping |
| qack_i | input | 1 | Quiesce acknowledge from system logic |
| pll_lock_i | input | 1 | PLL lock indication |
| qreq_o | output | 1 | Quiesce request to system logic |
| clk_en_o | output | 7 | Per-domain clock enables |

## Verification
Two functions can collide in one cycle. In nap, a wake event can coincide with a dropped acknowledge plus snoop-needed, which would otherwise start a doze excursion. In sleep, a wake event can coincide with the deep-sleep request. The bench drives both inputs together on a single negative edge. It then expects full enables with the request low after the next rising edge, not the doze pattern and not the all-off pattern.

// File: rtl/pwr_mode_pkg.sv
package pwr_mode_pkg;
  localparam int NUM_DOM = 7;
  localparam int DOM_FETCH = 0;
  localparam int DOM_UNITS = 1;
  localparam int DOM_SNOOP = 2;
  localparam int DOM_THERM = 3;
  localparam int DOM_TBASE = 4;
  localparam int DOM_TEST  = 5;
  localparam int DOM_PLL   = 6;

  typedef enum logic [1:0] {
    MODE_NONE  = 2'b00,
    MODE_NAP   = 2'b01,
    MODE_SLEEP = 2'b10,
    MODE_DEEP  = 2'b11
  } mode_e;

  typedef enum logic [2:0] {
    ST_RUN    = 3'd0,
    ST_NAP_W  = 3'd1,
    ST_SLP_W  = 3'd2,
    ST_NAP    = 3'd3,
    ST_DOZE   = 3'd4,
    ST_SLEEP  = 3'd5,
    ST_DEEP   = 3'd6,
    ST_RELOCK = 3'd7
  } pstate_e;

  // Is domain d clocked in state s
  function automatic logic dom_on(pstate_e s, int d);
    logic r;
    case (s)
      ST_RUN, ST_NAP_W, ST_SLP_W: r = 1'b1;
      ST_NAP:    r = (d == DOM_THERM) || (d == DOM_TBASE) ||
                     (d == DOM_TEST)  || (d == DOM_PLL);
      ST_DOZE:   r = (d == DOM_THERM) || (d == DOM_TBASE) ||
                     (d == DOM_TEST)  || (d == DOM_PLL) || (d == DOM_SNOOP);
      ST_SLEEP,
      ST_RELOCK: r = (d == DOM_PLL);
      default:   r = 1'b0;
    endcase
    return r;
  endfunction
endpackage

// File: rtl/pwr_rst_sync.sv
module pwr_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/pwr_mode_fsm.sv
module pwr_mode_fsm
  import pwr_mode_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] mode_i,
  input  logic       wake_i,
  input  logic       snoop_need_i,
  input  logic       qack_i,
  input  logic       pll_lock_i,
  output pstate_e    state_o,
  output logic       qreq_o
);
  pstate_e state_q, state_d;
  mode_e   mode;

  assign mode = mode_e'(mode_i);

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_RUN: begin
        if (!wake_i) begin
          if (mode == MODE_NAP)                             state_d = ST_NAP_W;
          else if (mode == MODE_SLEEP || mode == MODE_DEEP) state_d = ST_SLP_W;
        end
      end
      ST_NAP_W:  if (wake_i) state_d = ST_RUN; else if (qack_i) state_d = ST_NAP;
      ST_SLP_W:  if (wake_i) state_d = ST_RUN; else if (qack_i) state_d = ST_SLEEP;
      ST_NAP: begin
        if (wake_i)                        state_d = ST_RUN;
        else if (!qack_i && snoop_need_i)  state_d = ST_DOZE;
      end
      ST_DOZE:   if (wake_i) state_d = ST_RUN; else if (qack_i) state_d = ST_NAP;
      ST_SLEEP: begin
        if (wake_i)                  state_d = ST_RUN;
        else if (mode == MODE_DEEP)  state_d = ST_DEEP;
      end
      ST_DEEP:   if (wake_i) state_d = ST_RELOCK;
      ST_RELOCK: if (pll_lock_i) state_d = ST_RUN;
      default:   state_d = ST_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_RUN;
    else        state_q <= state_d;
  end

  assign state_o = state_q;
  assign qreq_o  = (state_q != ST_RUN);

  // R2: entry waits for acknowledge
  p_entry_waits_ack_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_NAP_W && !qack_i && !wake_i) |=> (state_q == ST_NAP_W));
  // R5: wake returns to run from quiesced states
  p_wake_to_run_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ((state_q == ST_NAP || state_q == ST_DOZE || state_q == ST_SLEEP ||
      state_q == ST_NAP_W || state_q == ST_SLP_W) && wake_i) |=> (state_q == ST_RUN));
  // R6: deep sleep only after sleep
  p_deep_from_sleep_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_DEEP && $past(state_q) != ST_DEEP) |-> ($past(state_q) == ST_SLEEP));
  // R7: relock holds until lock
  p_relock_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_RELOCK && !pll_lock_i) |=> (state_q == ST_RELOCK));
  // R8: nap ignores mode requests
  p_nap_ignores_mode_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_NAP && !wake_i) |=> (state_q == ST_NAP || state_q == ST_DOZE));
  // R9: sleep never snoops
  p_sleep_no_doze_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_SLEEP && !wake_i && mode_i != MODE_DEEP) |=> (state_q == ST_SLEEP));
endmodule

// File: rtl/pwr_clk_decode.sv
module pwr_clk_decode
  import pwr_mode_pkg::*;
(
  input  pstate_e            state_i,
  output logic [NUM_DOM-1:0] clk_en_o
);
  for (genvar d = 0; d < NUM_DOM; d++) begin : g_dom
    assign clk_en_o[d] = dom_on(state_i, d);
  end
endmodule

// File: rtl/pwr_mode_ctrl.sv
module pwr_mode_ctrl
  import pwr_mode_pkg::*;
#(
  parameter int RST_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [1:0]         mode_i,
  input  logic               wake_i,
  input  logic               snoop_need_i,
  input  logic               qack_i,
  input  logic               pll_lock_i,
  output logic               qreq_o,
  output logic [NUM_DOM-1:0] clk_en_o
);
  localparam logic [NUM_DOM-1:0] ALL_ON = {NUM_DOM{1'b1}};

  logic    rst_sync_n;
  pstate_e state;

  pwr_rst_sync #(.STAGES(RST_STAGES)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  pwr_mode_fsm u_fsm (
    .clk          (clk),
    .rst_n        (rst_sync_n),
    .mode_i       (mode_i),
    .wake_i       (wake_i),
    .snoop_need_i (snoop_need_i),
    .qack_i       (qack_i),
    .pll_lock_i   (pll_lock_i),
    .state_o      (state),
    .qreq_o       (qreq_o)
  );

  pwr_clk_decode u_dec (
    .state_i  (state),
    .clk_en_o (clk_en_o)
  );

  // R2: no domain gated without an outstanding quiesce request
  p_gate_needs_qreq_r2: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (clk_en_o != ALL_ON) |-> qreq_o);
  // R7: with the PLL off last cycle, no other domain may start now
  p_pll_first_r7: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $past(!clk_en_o[DOM_PLL]) |-> (clk_en_o[DOM_PLL-1:0] == '0));
endmodule

// File: tb/pwr_mode_ctrl_tb_top.sv
module pwr_mode_ctrl_tb_top;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [1:0] mode_i;
  logic       wake_i, snoop_need_i, qack_i, pll_lock_i;
  logic       qreq_o;
  logic [6:0] clk_en_o;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  typedef struct {
    logic [6:0] en;
    logic       q;
    string      tag;
  } exp_t;
  exp_t exp_q[$];

  always #4 clk = ~clk;

  pwr_mode_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .mode_i(mode_i), .wake_i(wake_i),
    .snoop_need_i(snoop_need_i), .qack_i(qack_i), .pll_lock_i(pll_lock_i),
    .qreq_o(qreq_o), .clk_en_o(clk_en_o)
  );

  // Driver: apply one cycle of inputs and push the expected result
  task automatic step(input logic [1:0] m, input logic w, input logic s,
                      input logic a, input logic l,
                      input logic [6:0] en, input logic q, input string tag);
    exp_t e;
    @(negedge clk);
    mode_i = m; wake_i = w; snoop_need_i = s; qack_i = a; pll_lock_i = l;
    e.en = en; e.q = q; e.tag = tag;
    exp_q.push_back(e);
  endtask

  // Monitor: compare after each rising edge
  always @(posedge clk) begin
    #2;
    if (exp_q.size() > 0) begin
      exp_t e;
      e = exp_q.pop_front();
      n_checks++;
      if (clk_en_o !== e.en || qreq_o !== e.q) begin
        n_fail++;
        $display("FAIL %s: en=%h qreq=%b expected en=%h qreq=%b",
                 e.tag, clk_en_o, qreq_o, e.en, e.q);
      end
    end
  end

  initial begin
    for (int c = 0; c < 20000; c++) @(posedge clk);
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: en=%h qreq=%b expected completion", clk_en_o, qreq_o);
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; mode_i = 2'b00; wake_i = 0; snoop_need_i = 0; qack_i = 0; pll_lock_i = 1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    step(2'b00,0,0,0,1, 7'h7F,0, "R1 reset");
    step(2'b00,0,0,0,1, 7'h7F,0, "R1 reset");
    step(2'b00,0,0,0,1, 7'h7F,0, "R1 reset");
    // R2 nap entry handshake
    step(2'b01,0,0,0,1, 7'h7F,1, "R2 request raised");
    step(2'b00,0,0,0,1, 7'h7F,1, "R2 wait for ack");
    step(2'b00,0,0,1,1, 7'h78,1, "R2 nap gated");
    // R8 sleep request in nap ignored
    step(2'b10,0,0,1,1, 7'h78,1, "R8 sleep req in nap");
    // R4 doze excursion
    step(2'b00,0,0,0,1, 7'h78,1, "R4 ack low no snoop");
    step(2'b00,0,1,0,1, 7'h7C,1, "R4 doze");
    step(2'b01,0,0,0,1, 7'h7C,1, "R4 doze held, R8 ignored");
    step(2'b00,0,0,1,1, 7'h78,1, "R4 back to nap");
    // R5 wake against snoop in the same cycle
    step(2'b00,1,1,0,1, 7'h7F,0, "R5 wake beats doze");
    step(2'b00,0,0,0,1, 7'h7F,0, "R5 run");
    // R3 sleep entry
    step(2'b10,0,0,0,1, 7'h7F,1, "R3 request raised");
    step(2'b00,0,0,1,1, 7'h40,1, "R3 sleep gated");
    step(2'b00,0,1,0,1, 7'h40,1, "R9 no doze in sleep");
    step(2'b01,0,0,1,1, 7'h40,1, "R8 nap req in sleep");
    // R5 wake against deep request in sleep
    step(2'b11,1,0,1,1, 7'h7F,0, "R5 wake beats deep");
    step(2'b00,0,0,0,1, 7'h7F,0, "R5 run");
    // R6 deep only via sleep
    step(2'b11,0,0,0,1, 7'h7F,1, "R6 request raised");
    step(2'b11,0,0,1,1, 7'h40,1, "R6 run to sleep first");
    step(2'b11,0,0,1,0, 7'h00,1, "R6 deep");
    step(2'b00,0,0,1,0, 7'h00,1, "R6 deep held");
    // R7 relock
    step(2'b00,1,0,1,0, 7'h40,1, "R7 pll first");
    step(2'b00,0,0,1,0, 7'h40,1, "R7 wake pending");
    step(2'b00,0,0,1,0, 7'h40,1, "R7 wake pending");
    step(2'b00,0,0,1,1, 7'h7F,0, "R7 locked to run");
    // R5 abort during entry wait
    step(2'b01,0,0,0,1, 7'h7F,1, "R5 nap request");
    step(2'b00,1,0,0,1, 7'h7F,0, "R5 wake aborts entry");
    step(2'b00,0,0,0,1, 7'h7F,0, "R1 idle");
    @(negedge clk); @(negedge clk);
    done = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule